// File: doc/BRIEF.md
# Frequency Level Step Controller

This block moves the core clock between a small set of operating levels when a load tracker asks for more or less speed. Level index 0 is the fastest setting and the highest index is the slowest. Each cycle the block looks at a two-bit event code, a mask bit and an update-ready flag from the clock controller. When an event is accepted, the block picks the new level and runs a fixed change sequence. It issues a control strobe, waits a programmable voltage ramp, and then applies the new post-divider setting. When the PLL assigned to the new level is not the one in use, it also switches PLLs and reprograms that PLL.

A voltage-tracking handshake runs alongside the sequence. While tracking is enabled, its change request is withdrawn for the length of the update. The request is reasserted when the divider is applied, and the valid flag follows after a programmable settle time. The PLL, the dividers and the regulator sit outside the block. The block only drives strobes and configuration words toward them. It has no back-pressure: the event code is a plain level that is sampled on every clock and simply dropped when it cannot be taken.

Three saturating counters report how many slow-down, speed-up and panic events actually changed the level.

Top module: `freq_step_ctrl`

## Requirements
- R1: Event code 1 (slower) raises the level index by one. It is ignored when the index is already NUM_LEVELS-1.
- R2: Event code 2 (faster) lowers the level index by one. It is ignored at index 0.
- R3: Event code 3 (panic) sets the index to 0 in a single step. It is ignored at index 0.
- R4: Code 0 changes nothing. Neither does any event sampled while evt_mask is high.
- R5: An event is ignored when upd_ready is low or while a change sequence is running (seq_busy high).
- R6: An accepted event pulses ctrl_stb for one cycle, and level takes the new index in that same cycle. If the new index is larger than the old one, up_flag is 1 and vstep is target+2. Otherwise up_flag is 0 and vstep is 1.
- R7: Levels below NUM_LEVELS/2 use PLL 0 and the rest use PLL 1. If the target's PLL differs from the one in use, pll_sel flips together with ctrl_stb. In that case pll_prog_stb pulses together with div_stb and pll_cfg becomes 0x30+target. Otherwise pll_prog_stb stays low.
- R8: div_stb pulses exactly RAMP_CYC cycles after ctrl_stb, and div_cfg becomes target+1.
- R9: vt_req and vt_valid are always 0 while vt_en is low. While vt_en is high, both drop with ctrl_stb. vt_req returns with div_stb, and vt_valid returns SETTLE_CYC cycles after that, which ends the sequence.
- R10: cnt_dec, cnt_inc and cnt_pan each count accepted events of their kind and hold at 2^CNT_W-1.
- R11: After reset, level is RESET_LEVEL, pll_sel and div_cfg match that level, the counters are 0, no strobe is high, seq_busy is 0, and vt_req and vt_valid follow vt_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_code | input | 2 | Load event: 0 none, 1 slower, 2 faster, 3 panic |
| evt_mask | input | 1 | When high, events are ignored |
| upd_ready | input | 1 | Clock controller can take a new update |
| vt_en | input | 1 | Voltage tracking enabled |
| level | output | LVL_W | Current level index (0 fastest) |
| seq_busy | output | 1 | Change sequence in progress |
| ctrl_stb | output | 1 | One-cycle control update strobe |
| up_flag | output | 1 | New index larger than the old one |
| vstep | output | VSTEP_W | Voltage step count for this change |
| pll_sel | output | 1 | PLL in use |
| div_stb | output | 1 | One-cycle divider apply strobe |
| div_cfg | output | DIV_W | Post-divider word |
| pll_prog_stb | output | 1 | One-cycle PLL reprogram strobe |
| pll_cfg | output | CFG_W | PLL configuration word |
| vt_req | output | 1 | Voltage-change request toward tracking |
| vt_valid | output | 1 | Voltage valid toward tracking |
| cnt_dec | output | CNT_W | Accepted slower events, saturating |
| cnt_inc | output | CNT_W | Accepted faster events, saturating |
| cnt_pan | output | CNT_W | Accepted panic events, saturating |

## Verification
Some properties are checked on every cycle. For each event kind, the level step seen at ctrl_stb must match the event. Strobes must only fire after an event that was ready, unmasked and arrived while the block was idle. up_flag and vstep must agree with the direction of the move. The tracking outputs must be silent when tracking is off, and the counters may only move by one at a control strobe. The exact ramp and settle distances, the divider and PLL words, saturation after many events, and events injected mid-sequence can only be shown by the bench's scenarios. The bench runs directed boundary events and then seeded random streams of codes, masks and ready levels.

// File: rtl/freq_step_pkg.sv
package freq_step_pkg;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_SLOWER = 2'd1,
    EV_FASTER = 2'd2,
    EV_PANIC  = 2'd3
  } evt_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RAMP   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_st_e;

  // Level table contents, computed rather than listed
  function automatic int unsigned lvl_vstep(input int unsigned l);
    return l + 2;
  endfunction

  function automatic logic lvl_pll(input int unsigned l, input int unsigned n);
    return (l >= n / 2) ? 1'b1 : 1'b0;
  endfunction

  function automatic int unsigned lvl_div(input int unsigned l);
    return l + 1;
  endfunction

  function automatic int unsigned lvl_cfg(input int unsigned l);
    return 32'h30 + l;
  endfunction

endpackage

// File: rtl/freq_step_rom.sv
module freq_step_rom
  import freq_step_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = 2,
  parameter int VSTEP_W    = 4,
  parameter int DIV_W      = 4,
  parameter int CFG_W      = 8
) (
  input  logic [LVL_W-1:0]   idx,
  output logic [VSTEP_W-1:0] vstep,
  output logic               pll_b,
  output logic [DIV_W-1:0]   div,
  output logic [CFG_W-1:0]   cfg
);

  logic [VSTEP_W-1:0] vstep_tab [NUM_LEVELS];
  logic               pll_tab   [NUM_LEVELS];
  logic [DIV_W-1:0]   div_tab   [NUM_LEVELS];
  logic [CFG_W-1:0]   cfg_tab   [NUM_LEVELS];

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_entry
    assign vstep_tab[i] = VSTEP_W'(lvl_vstep(i));
    assign pll_tab[i]   = lvl_pll(i, NUM_LEVELS);
    assign div_tab[i]   = DIV_W'(lvl_div(i));
    assign cfg_tab[i]   = CFG_W'(lvl_cfg(i));
  end

  assign vstep = vstep_tab[idx];
  assign pll_b = pll_tab[idx];
  assign div   = div_tab[idx];
  assign cfg   = cfg_tab[idx];

endmodule

// File: rtl/freq_step_decode.sv
module freq_step_decode
  import freq_step_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = 2
) (
  input  logic [1:0]       evt_code,
  input  logic             evt_mask,
  input  logic             upd_ready,
  input  logic             idle,
  input  logic [LVL_W-1:0] cur_level,
  output logic             go,
  output logic [LVL_W-1:0] target,
  output logic [2:0]       kind
);

  localparam logic [LVL_W-1:0] LAST = LVL_W'(NUM_LEVELS - 1);

  evt_e ev;
  assign ev = evt_e'(evt_code);

  always_comb begin
    target = cur_level;
    kind   = 3'b000;
    case (ev)
      EV_SLOWER: begin
        kind[0] = 1'b1;
        if (cur_level != LAST) target = cur_level + LVL_W'(1);
      end
      EV_FASTER: begin
        kind[1] = 1'b1;
        if (cur_level != '0) target = cur_level - LVL_W'(1);
      end
      EV_PANIC: begin
        kind[2] = 1'b1;
        target  = '0;
      end
      default: ;
    endcase
  end

  assign go = idle && upd_ready && !evt_mask && (target != cur_level);

endmodule

// File: rtl/freq_step_seq.sv
module freq_step_seq
  import freq_step_pkg::*;
#(
  parameter int          NUM_LEVELS  = 4,
  parameter int          LVL_W       = 2,
  parameter int          VSTEP_W     = 4,
  parameter int          DIV_W       = 4,
  parameter int          CFG_W       = 8,
  parameter int          RAMP_CYC    = 12,
  parameter int          SETTLE_CYC  = 3,
  parameter int unsigned RESET_LEVEL = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [LVL_W-1:0]   target,
  input  logic               vt_en,
  input  logic [VSTEP_W-1:0] tgt_vstep,
  input  logic               tgt_pll,
  input  logic [DIV_W-1:0]   tgt_div,
  input  logic [CFG_W-1:0]   tgt_cfg,
  output logic [LVL_W-1:0]   level,
  output logic               busy,
  output logic               ctrl_stb,
  output logic               up_flag,
  output logic [VSTEP_W-1:0] vstep,
  output logic               pll_sel,
  output logic               div_stb,
  output logic [DIV_W-1:0]   div_cfg,
  output logic               pll_prog_stb,
  output logic [CFG_W-1:0]   pll_cfg,
  output logic               vreq_hold,
  output logic               valid_hold
);

  localparam int TMAX  = (RAMP_CYC > SETTLE_CYC) ? RAMP_CYC : SETTLE_CYC;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam logic [TMR_W-1:0] RAMP_LD   = TMR_W'(RAMP_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);

  seq_st_e            state;
  logic [TMR_W-1:0]   tmr;
  logic               switch_pend;
  logic [DIV_W-1:0]   pend_div;
  logic [CFG_W-1:0]   pend_cfg;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      tmr          <= '0;
      level        <= LVL_W'(RESET_LEVEL);
      ctrl_stb     <= 1'b0;
      up_flag      <= 1'b0;
      vstep        <= VSTEP_W'(1);
      pll_sel      <= lvl_pll(RESET_LEVEL, NUM_LEVELS);
      div_stb      <= 1'b0;
      div_cfg      <= DIV_W'(lvl_div(RESET_LEVEL));
      pll_prog_stb <= 1'b0;
      pll_cfg      <= CFG_W'(lvl_cfg(RESET_LEVEL));
      switch_pend  <= 1'b0;
      pend_div     <= '0;
      pend_cfg     <= '0;
      vreq_hold    <= 1'b1;
      valid_hold   <= 1'b1;
    end else begin
      ctrl_stb     <= 1'b0;
      div_stb      <= 1'b0;
      pll_prog_stb <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go) begin
            ctrl_stb    <= 1'b1;
            level       <= target;
            up_flag     <= (target > level);
            vstep       <= (target > level) ? tgt_vstep : VSTEP_W'(1);
            switch_pend <= (tgt_pll != pll_sel);
            pll_sel     <= tgt_pll;
            pend_div    <= tgt_div;
            pend_cfg    <= tgt_cfg;
            vreq_hold   <= 1'b0;
            valid_hold  <= 1'b0;
            tmr         <= RAMP_LD;
            state       <= ST_RAMP;
          end
        end
        ST_RAMP: begin
          if (tmr == '0) begin
            div_stb   <= 1'b1;
            div_cfg   <= pend_div;
            vreq_hold <= 1'b1;
            if (switch_pend) begin
              pll_prog_stb <= 1'b1;
              pll_cfg      <= pend_cfg;
            end
            if (vt_en) begin
              tmr   <= SETTLE_LD;
              state <= ST_SETTLE;
            end else begin
              valid_hold <= 1'b1;
              state      <= ST_IDLE;
            end
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        ST_SETTLE: begin
          if (tmr == '0) begin
            valid_hold <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/freq_step_counters.sv
module freq_step_counters #(
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [2:0]            kind,
  output logic [2:0][CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  for (genvar k = 0; k < 3; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[k] <= '0;
      else if (go && kind[k] && (cnt[k] != CMAX))
        cnt[k] <= cnt[k] + CNT_W'(1);
    end
  end

endmodule

// File: rtl/freq_step_ctrl.sv
module freq_step_ctrl #(
  parameter int          NUM_LEVELS  = 4,
  parameter int          LVL_W       = $clog2(NUM_LEVELS),
  parameter int          VSTEP_W     = 4,
  parameter int          DIV_W       = 4,
  parameter int          CFG_W       = 8,
  parameter int          CNT_W       = 4,
  parameter int          RAMP_CYC    = 12,
  parameter int          SETTLE_CYC  = 3,
  parameter int unsigned RESET_LEVEL = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         evt_code,
  input  logic               evt_mask,
  input  logic               upd_ready,
  input  logic               vt_en,
  output logic [LVL_W-1:0]   level,
  output logic               seq_busy,
  output logic               ctrl_stb,
  output logic               up_flag,
  output logic [VSTEP_W-1:0] vstep,
  output logic               pll_sel,
  output logic               div_stb,
  output logic [DIV_W-1:0]   div_cfg,
  output logic               pll_prog_stb,
  output logic [CFG_W-1:0]   pll_cfg,
  output logic               vt_req,
  output logic               vt_valid,
  output logic [CNT_W-1:0]   cnt_dec,
  output logic [CNT_W-1:0]   cnt_inc,
  output logic [CNT_W-1:0]   cnt_pan
);

  logic               go;
  logic [LVL_W-1:0]   target;
  logic [2:0]         kind;
  logic [VSTEP_W-1:0] tgt_vstep;
  logic               tgt_pll;
  logic [DIV_W-1:0]   tgt_div;
  logic [CFG_W-1:0]   tgt_cfg;
  logic               vreq_hold;
  logic               valid_hold;
  logic [2:0][CNT_W-1:0] cnt;

  freq_step_decode #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_dec (
    .evt_code (evt_code),
    .evt_mask (evt_mask),
    .upd_ready(upd_ready),
    .idle     (!seq_busy),
    .cur_level(level),
    .go       (go),
    .target   (target),
    .kind     (kind)
  );

  freq_step_rom #(
    .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .VSTEP_W(VSTEP_W),
    .DIV_W(DIV_W), .CFG_W(CFG_W)
  ) u_rom (
    .idx  (target),
    .vstep(tgt_vstep),
    .pll_b(tgt_pll),
    .div  (tgt_div),
    .cfg  (tgt_cfg)
  );

  freq_step_seq #(
    .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .VSTEP_W(VSTEP_W),
    .DIV_W(DIV_W), .CFG_W(CFG_W), .RAMP_CYC(RAMP_CYC),
    .SETTLE_CYC(SETTLE_CYC), .RESET_LEVEL(RESET_LEVEL)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .target      (target),
    .vt_en       (vt_en),
    .tgt_vstep   (tgt_vstep),
    .tgt_pll     (tgt_pll),
    .tgt_div     (tgt_div),
    .tgt_cfg     (tgt_cfg),
    .level       (level),
    .busy        (seq_busy),
    .ctrl_stb    (ctrl_stb),
    .up_flag     (up_flag),
    .vstep       (vstep),
    .pll_sel     (pll_sel),
    .div_stb     (div_stb),
    .div_cfg     (div_cfg),
    .pll_prog_stb(pll_prog_stb),
    .pll_cfg     (pll_cfg),
    .vreq_hold   (vreq_hold),
    .valid_hold  (valid_hold)
  );

  freq_step_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (go),
    .kind (kind),
    .cnt  (cnt)
  );

  assign cnt_dec  = cnt[0];
  assign cnt_inc  = cnt[1];
  assign cnt_pan  = cnt[2];
  assign vt_req   = vt_en && vreq_hold;
  assign vt_valid = vt_en && valid_hold;

endmodule

// File: rtl/freq_step_ctrl_chk.sv
module freq_step_ctrl_chk #(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = 2,
  parameter int VSTEP_W    = 4,
  parameter int CNT_W      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         evt_code,
  input logic               evt_mask,
  input logic               upd_ready,
  input logic               vt_en,
  input logic [LVL_W-1:0]   level,
  input logic               seq_busy,
  input logic               ctrl_stb,
  input logic               up_flag,
  input logic [VSTEP_W-1:0] vstep,
  input logic               div_stb,
  input logic               pll_prog_stb,
  input logic               vt_req,
  input logic               vt_valid,
  input logic [CNT_W-1:0]   cnt_dec,
  input logic [CNT_W-1:0]   cnt_inc,
  input logic [CNT_W-1:0]   cnt_pan
);

  p_slower_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stb && $past(evt_code) == 2'd1) |-> level == $past(level) + LVL_W'(1));

  p_faster_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stb && $past(evt_code) == 2'd2) |-> level == $past(level) - LVL_W'(1));

  p_panic_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stb && $past(evt_code) == 2'd3) |-> level == '0);

  p_level_only_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ctrl_stb);

  p_accept_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb |-> ($past(upd_ready) && !$past(evt_mask) && !$past(seq_busy)
                  && $past(evt_code) != 2'd0));

  p_dir_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb |-> up_flag == (level > $past(level)));

  p_down_vstep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stb && !up_flag) |-> vstep == VSTEP_W'(1));

  p_pll_with_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pll_prog_stb |-> div_stb);

  p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_stb, div_stb}));

  p_vt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vt_en |-> (!vt_req && !vt_valid));

  p_valid_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vt_valid |-> vt_req);

  p_dec_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dec != $past(cnt_dec)) |-> (ctrl_stb && cnt_dec == $past(cnt_dec) + CNT_W'(1)));

  p_inc_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc != $past(cnt_inc)) |-> (ctrl_stb && cnt_inc == $past(cnt_inc) + CNT_W'(1)));

  p_pan_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pan != $past(cnt_pan)) |-> (ctrl_stb && cnt_pan == $past(cnt_pan) + CNT_W'(1)));

endmodule

bind freq_step_ctrl freq_step_ctrl_chk #(
  .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .VSTEP_W(VSTEP_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_code    (evt_code),
  .evt_mask    (evt_mask),
  .upd_ready   (upd_ready),
  .vt_en       (vt_en),
  .level       (level),
  .seq_busy    (seq_busy),
  .ctrl_stb    (ctrl_stb),
  .up_flag     (up_flag),
  .vstep       (vstep),
  .div_stb     (div_stb),
  .pll_prog_stb(pll_prog_stb),
  .vt_req      (vt_req),
  .vt_valid    (vt_valid),
  .cnt_dec     (cnt_dec),
  .cnt_inc     (cnt_inc),
  .cnt_pan     (cnt_pan)
);

// File: tb/freq_step_ctrl_test.sv
module freq_step_ctrl_test;

  localparam int NL     = 4;
  localparam int LW     = 2;
  localparam int RAMP   = 12;
  localparam int SETTLE = 3;
  localparam int CW     = 4;
  localparam int CMAX   = (1 << CW) - 1;
  localparam int RSTLVL = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] evt_code = 2'd0;
  logic evt_mask = 1'b0;
  logic upd_ready = 1'b1;
  logic vt_en = 1'b1;
  logic [LW-1:0] level;
  logic seq_busy, ctrl_stb, up_flag, pll_sel, div_stb, pll_prog_stb, vt_req, vt_valid;
  logic [3:0] vstep, div_cfg;
  logic [7:0] pll_cfg;
  logic [CW-1:0] cnt_dec, cnt_inc, cnt_pan;

  always #4 clk = ~clk;

  freq_step_ctrl #(
    .NUM_LEVELS(NL), .LVL_W(LW), .VSTEP_W(4), .DIV_W(4), .CFG_W(8), .CNT_W(CW),
    .RAMP_CYC(RAMP), .SETTLE_CYC(SETTLE), .RESET_LEVEL(RSTLVL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .evt_code(evt_code), .evt_mask(evt_mask),
    .upd_ready(upd_ready), .vt_en(vt_en), .level(level), .seq_busy(seq_busy),
    .ctrl_stb(ctrl_stb), .up_flag(up_flag), .vstep(vstep), .pll_sel(pll_sel),
    .div_stb(div_stb), .div_cfg(div_cfg), .pll_prog_stb(pll_prog_stb),
    .pll_cfg(pll_cfg), .vt_req(vt_req), .vt_valid(vt_valid),
    .cnt_dec(cnt_dec), .cnt_inc(cnt_inc), .cnt_pan(cnt_pan)
  );

  int vecs = 0;
  int fails = 0;
  bit finished = 1'b0;
  int m_level = RSTLVL;
  int m_pll = 0;
  int m_cnt [3] = '{0, 0, 0};

  function automatic int f_target(input int code, input int l);
    case (code)
      1: return (l == NL - 1) ? l : l + 1;
      2: return (l == 0) ? 0 : l - 1;
      3: return 0;
      default: return l;
    endcase
  endfunction

  function automatic int f_pll(input int l);
    return (l >= NL / 2) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_idle();
    while (seq_busy) step();
  endtask

  // Drives one event for one cycle from an idle state and follows the sequence.
  task automatic do_event(input int code, input bit mask, input bit rdy,
                          input bit vt, input bit intrude);
    int tgt, old, kind;
    bit acc, sw;
    wait_idle();
    vt_en = vt;
    evt_code = 2'(code);
    evt_mask = mask;
    upd_ready = rdy;
    old = m_level;
    tgt = f_target(code, old);
    acc = rdy && !mask && (code != 0) && (tgt != old);
    step();
    evt_code = 2'd0;
    evt_mask = 1'b0;
    upd_ready = 1'b1;
    if (acc) begin
      kind = code - 1;
      if (m_cnt[kind] < CMAX) m_cnt[kind]++;
    end
    chk(acc ? "R6 ctrl_stb" : "R4 ctrl_stb idle", int'(ctrl_stb), int'(acc));
    chk(code == 1 ? "R1 level" : code == 2 ? "R2 level" : code == 3 ? "R3 level" : "R4 level",
        int'(level), acc ? tgt : old);
    chk("R10 cnt_dec", int'(cnt_dec), m_cnt[0]);
    chk("R10 cnt_inc", int'(cnt_inc), m_cnt[1]);
    chk("R10 cnt_pan", int'(cnt_pan), m_cnt[2]);
    if (!acc) return;
    sw = (f_pll(tgt) != m_pll);
    chk("R6 up_flag", int'(up_flag), int'(tgt > old));
    chk("R6 vstep", int'(vstep), (tgt > old) ? tgt + 2 : 1);
    chk("R7 pll_sel at ctrl", int'(pll_sel), f_pll(tgt));
    chk("R9 vt_req dropped", int'(vt_req), 0);
    chk("R9 vt_valid dropped", int'(vt_valid), 0);
    m_level = tgt;
    m_pll = f_pll(tgt);
    for (int k = 1; k <= RAMP; k++) begin
      if (intrude && k == 1) begin
        evt_code = 2'd3;
        upd_ready = 1'b1;
      end
      if (intrude && k == RAMP / 2) evt_code = 2'd0;
      step();
      if (intrude) chk("R5 busy ignore level", int'(level), tgt);
      if (k < RAMP) begin
        chk("R8 div_stb early", int'(div_stb), 0);
      end else begin
        chk("R8 div_stb at ramp", int'(div_stb), 1);
        chk("R8 div_cfg", int'(div_cfg), tgt + 1);
        chk("R7 pll_prog_stb", int'(pll_prog_stb), int'(sw));
        if (sw) chk("R7 pll_cfg", int'(pll_cfg), 8'h30 + tgt);
        chk("R9 vt_req back", int'(vt_req), int'(vt));
        chk("R9 vt_valid low", int'(vt_valid), 0);
      end
    end
    if (vt) begin
      for (int j = 1; j <= SETTLE; j++) begin
        step();
        chk("R9 vt_valid settle", int'(vt_valid), int'(j == SETTLE));
      end
    end
    chk("R5 busy released", int'(seq_busy), 0);
    if (intrude) chk("R5 cnt_pan after intrusion", int'(cnt_pan), m_cnt[2]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 level", int'(level), RSTLVL);
    chk("R11 busy", int'(seq_busy), 0);
    chk("R11 ctrl_stb", int'(ctrl_stb), 0);
    chk("R11 div_stb", int'(div_stb), 0);
    chk("R11 pll_sel", int'(pll_sel), f_pll(RSTLVL));
    chk("R11 div_cfg", int'(div_cfg), RSTLVL + 1);
    chk("R11 counters", int'(cnt_dec) + int'(cnt_inc) + int'(cnt_pan), 0);
    chk("R11 vt_req", int'(vt_req), 1);
    chk("R11 vt_valid", int'(vt_valid), 1);
    vt_en = 1'b0;
    #1;
    chk("R9 vt_req off", int'(vt_req), 0);

    do_event(1, 0, 1, 1, 0);  // R1 1->2 with PLL switch (R7)
    do_event(1, 0, 1, 0, 0);  // R1 2->3, no switch, tracking off
    do_event(1, 0, 1, 1, 0);  // R1 at last level: ignored
    do_event(2, 0, 1, 1, 0);  // R2 3->2, R6 down step count
    do_event(3, 0, 1, 1, 0);  // R3 2->0 with PLL switch back
    do_event(2, 0, 1, 1, 0);  // R2 at 0: ignored
    do_event(3, 0, 1, 0, 0);  // R3 at 0: ignored
    do_event(1, 1, 1, 1, 0);  // R4 masked
    do_event(0, 0, 1, 1, 0);  // R4 no event
    do_event(1, 0, 0, 1, 0);  // R5 not ready
    do_event(1, 0, 1, 1, 1);  // R5 panic injected while busy

    for (int i = 0; i < 80; i++) begin
      do_event(int'($urandom % 4), ($urandom % 4) == 0, ($urandom % 5) != 0,
               bit'($urandom % 2), 0);
    end

    // R10 saturation: drive to 0, then alternate slower/faster
    do_event(3, 0, 1, 0, 0);
    for (int i = 0; i < 18; i++) begin
      do_event(1, 0, 1, 0, 0);
      do_event(2, 0, 1, 0, 0);
    end
    chk("R10 cnt_dec saturated", int'(cnt_dec), CMAX);
    chk("R10 cnt_inc saturated", int'(cnt_inc), CMAX);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule